// File: doc/BRIEF.md
# Deadzone Bang-Bang Duty Controller

This block closes the voltage loop of a boost converter with a minimal digital control law. Two single-bit comparator results tell it whether the sensed output sits above the upper edge of a tolerance band or below its lower edge. On each update strobe, a saturating up/down counter holding the duty code moves one step toward the band. While the output stays inside the band, the counter does not move. Because of this hold region, the loop does not dither between two neighbouring duty codes once it has settled.

The duty code drives a pulse width modulator with a free-running period counter. The modulator produces the gate signal for the power switch. It takes a new duty code only at the start of a PWM period, so a period never contains a clipped or extra pulse.

A synchronous load port writes the duty register directly. A redundant partner controller can use this port to copy its state across after it recovers. Loaded values are clamped into the permitted duty range.

Top module: `dz_duty_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `duty_out` equals DUTY_MIN (default 4). While reset is high, `pwm_out` is 0.
- R2: If `upd_stb` is 1, `load_en` is 0, `below_lo` is 1 and `above_hi` is 0, then `duty_out` rises by one on the next cycle, unless it already equals DUTY_MAX.
- R3: If `upd_stb` is 1, `load_en` is 0, `above_hi` is 1 and `below_lo` is 0, then `duty_out` falls by one on the next cycle, unless it already equals DUTY_MIN.
- R4: If `upd_stb` is 1 and `load_en` is 0, and both comparator bits are 0 (inside the band) or both are 1 (invalid), then `duty_out` keeps its value.
- R5: If both `upd_stb` and `load_en` are 0, then `duty_out` keeps its value, whatever the comparator bits are.
- R6: `duty_out` always stays within DUTY_MIN..DUTY_MAX (defaults 4 and 240). A step past either limit leaves the value at that limit and never wraps.
- R7: If `load_en` is 1, then on the next cycle `duty_out` takes `load_val` clamped to DUTY_MIN..DUTY_MAX. A load takes priority over a strobe in the same cycle.
- R8: In steady state, every PWM period of 2^W cycles (256 by default) holds exactly `duty_out` high cycles of `pwm_out`, as one contiguous pulse that starts the period.
- R9: A duty change made partway through a period does not alter that period's pulse. The new width appears from the next period start.
- R10: Because DUTY_MAX is below 2^W, `pwm_out` goes low in every period, even at the maximum duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_lo | input | 1 | Output voltage is below the lower band threshold |
| above_hi | input | 1 | Output voltage is above the upper band threshold |
| upd_stb | input | 1 | One-cycle strobe that allows one control step |
| load_en | input | 1 | Synchronous load of an external duty value |
| load_val | input | W | Duty value to load (clamped) |
| pwm_out | output | 1 | Registered gate drive for the power switch |
| duty_out | output | W | Current duty code |

## Verification
The bound checker tests the counter law on every cycle:
- single steps up and down;
- holds inside the deadzone, on an invalid comparator pair and with no strobe;
- loads with clamping;
- the range limits;
- the reset value.

The PWM properties span a whole period, so only the bench scenarios show them. These are the pulse width per period, the low time at maximum duty, and the rule that a mid-period duty change leaves the current pulse untouched.

// File: rtl/dz_pkg.sv
package dz_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/dz_law.sv
// Deadzone decision: turns the two threshold bits into a step direction.
module dz_law
  import dz_pkg::*;
(
  input  logic  below_lo,
  input  logic  above_hi,
  output step_e step
);
  always_comb begin
    unique case ({below_lo, above_hi})
      2'b10:   step = STEP_UP;
      2'b01:   step = STEP_DOWN;
      default: step = STEP_HOLD; // inside band, or contradictory pair
    endcase
  end
endmodule

// File: rtl/dz_duty_acc.sv
// Saturating up/down duty register with clamped synchronous load.
module dz_duty_acc
  import dz_pkg::*;
#(
  parameter int W        = 8,
  parameter int DUTY_MIN = 4,
  parameter int DUTY_MAX = 240
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_stb,
  input  step_e        step,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] duty_q
);
  localparam logic [W-1:0] MIN_V = W'(DUTY_MIN);
  localparam logic [W-1:0] MAX_V = W'(DUTY_MAX);

  logic [W-1:0] load_clamped;

  always_comb begin
    if (load_val < MIN_V)      load_clamped = MIN_V;
    else if (load_val > MAX_V) load_clamped = MAX_V;
    else                       load_clamped = load_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= MIN_V;
    end else if (load_en) begin
      duty_q <= load_clamped;
    end else if (upd_stb) begin
      unique case (step)
        STEP_UP:   if (duty_q < MAX_V) duty_q <= duty_q + 1'b1;
        STEP_DOWN: if (duty_q > MIN_V) duty_q <= duty_q - 1'b1;
        default:   duty_q <= duty_q;
      endcase
    end
  end
endmodule

// File: rtl/dz_pwm.sv
// Free-running period counter; duty shadowed at period start; registered output.
module dz_pwm #(
  parameter int W        = 8,
  parameter int DUTY_MIN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] duty,
  output logic         pwm
);
  logic [W-1:0] pc_q;
  logic [W-1:0] shadow_q;
  logic [W-1:0] active;

  assign active = (pc_q == '0) ? duty : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      shadow_q <= W'(DUTY_MIN);
      pwm      <= 1'b0;
    end else begin
      pc_q     <= pc_q + 1'b1;
      shadow_q <= active;
      pwm      <= (pc_q < active);
    end
  end
endmodule

// File: rtl/dz_duty_ctrl.sv
module dz_duty_ctrl
  import dz_pkg::*;
#(
  parameter int W        = 8,
  parameter int DUTY_MIN = 4,
  parameter int DUTY_MAX = 240
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         below_lo,
  input  logic         above_hi,
  input  logic         upd_stb,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic         pwm_out,
  output logic [W-1:0] duty_out
);
  step_e step;

  dz_law u_law (
    .below_lo (below_lo),
    .above_hi (above_hi),
    .step     (step)
  );

  dz_duty_acc #(.W(W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .upd_stb  (upd_stb),
    .step     (step),
    .load_en  (load_en),
    .load_val (load_val),
    .duty_q   (duty_out)
  );

  dz_pwm #(.W(W), .DUTY_MIN(DUTY_MIN)) u_pwm (
    .clk  (clk),
    .rst  (rst),
    .duty (duty_out),
    .pwm  (pwm_out)
  );
endmodule

// File: rtl/dz_duty_ctrl_chk.sv
module dz_duty_ctrl_chk #(
  parameter int W        = 8,
  parameter int DUTY_MIN = 4,
  parameter int DUTY_MAX = 240
) (
  input logic         clk,
  input logic         rst,
  input logic         below_lo,
  input logic         above_hi,
  input logic         upd_stb,
  input logic         load_en,
  input logic [W-1:0] load_val,
  input logic         pwm_out,
  input logic [W-1:0] duty_out
);
  localparam logic [W-1:0] MIN_V = W'(DUTY_MIN);
  localparam logic [W-1:0] MAX_V = W'(DUTY_MAX);

  AST_RESET_DUTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> duty_out == MIN_V); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !load_en && below_lo && !above_hi && duty_out < MAX_V)
      |=> duty_out == $past(duty_out) + 1'b1); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !load_en && above_hi && !below_lo && duty_out > MIN_V)
      |=> duty_out == $past(duty_out) - 1'b1); // R3
  AST_DEADZONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !load_en && (below_lo == above_hi)) |=> $stable(duty_out)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!upd_stb && !load_en) |=> $stable(duty_out)); // R5
  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
    duty_out >= MIN_V && duty_out <= MAX_V); // R6
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (load_en && load_val >= MIN_V && load_val <= MAX_V)
      |=> duty_out == $past(load_val)); // R7
endmodule

bind dz_duty_ctrl dz_duty_ctrl_chk #(.W(W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_chk (
  .clk(clk), .rst(rst), .below_lo(below_lo), .above_hi(above_hi),
  .upd_stb(upd_stb), .load_en(load_en), .load_val(load_val),
  .pwm_out(pwm_out), .duty_out(duty_out)
);

// File: tb/dz_duty_ctrl_bench.sv
`timescale 1ns/1ps
module dz_duty_ctrl_bench;
  localparam int W = 8;
  localparam int PERIOD = 1 << W;
  localparam int NV = 16;
  // {upd, load, below, above, val[7:0], expected duty[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {4'b0100, 8'd100, 8'd100}, // R7 load
    {4'b1010, 8'd0,   8'd101}, // R2 up
    {4'b1010, 8'd0,   8'd102}, // R2 up
    {4'b1001, 8'd0,   8'd101}, // R3 down
    {4'b1000, 8'd0,   8'd101}, // R4 in band
    {4'b1011, 8'd0,   8'd101}, // R4 both set
    {4'b0010, 8'd0,   8'd101}, // R5 no strobe
    {4'b1110, 8'd238, 8'd238}, // R7 load beats strobe
    {4'b1010, 8'd0,   8'd239}, // R2
    {4'b1010, 8'd0,   8'd240}, // R2 reaches max
    {4'b1010, 8'd0,   8'd240}, // R6 saturate high
    {4'b0100, 8'd250, 8'd240}, // R7 clamp high
    {4'b0100, 8'd5,   8'd5},   // R7
    {4'b1001, 8'd0,   8'd4},   // R3 reaches min
    {4'b1001, 8'd0,   8'd4},   // R6 saturate low
    {4'b0100, 8'd2,   8'd4}    // R7 clamp low
  };

  logic clk = 0, rst = 1, below_lo = 0, above_hi = 0, upd_stb = 0, load_en = 0;
  logic [W-1:0] load_val = '0;
  logic pwm_out;
  logic [W-1:0] duty_out;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dz_duty_ctrl u_dz_duty_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int v);
    @(negedge clk); load_en = 1; load_val = W'(v);
    @(negedge clk); load_en = 0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (!prev && pwm_out) break;
      prev = pwm_out;
    end
  endtask

  // High cycles in one full period, starting at a rising edge.
  task automatic period_highs(output int n, output int lows);
    wait_rise();
    n = 1; lows = 0;
    for (int i = 1; i < PERIOD; i++) begin
      @(negedge clk);
      if (pwm_out) n++; else lows++;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, lo, run;
    repeat (3) @(negedge clk);
    chk("R1 duty in reset", duty_out, 4);
    chk("R1 pwm in reset", pwm_out, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 duty after reset", duty_out, 4);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {upd_stb, load_en, below_lo, above_hi} = VEC[i][19:16];
      load_val = VEC[i][15:8];
      @(negedge clk);
      {upd_stb, load_en, below_lo, above_hi} = 4'b0;
      chk($sformatf("R2-7 vector %0d", i), duty_out, VEC[i][7:0]);
    end

    // R8: steady pulse width
    load(100);
    wait_rise(); wait_rise();
    period_highs(n, lo);
    chk("R8 highs at 100", n, 100);
    load(37);
    wait_rise();
    period_highs(n, lo);
    chk("R8 highs at 37", n, 37);

    // R10: maximum duty still leaves low time
    load(240);
    wait_rise();
    period_highs(n, lo);
    chk("R10 highs at max", n, 240);
    chk("R10 low cycles at max", lo, 16);

    // R9: change mid-pulse, current pulse keeps old width
    load(100);
    wait_rise(); wait_rise();
    run = 1;
    repeat (9) begin @(negedge clk); if (pwm_out) run++; end
    load_en = 1; load_val = 8'd200;
    @(negedge clk); if (pwm_out) run++;
    load_en = 0;
    while (pwm_out) begin @(negedge clk); if (pwm_out) run++; end
    chk("R9 pulse in change period", run, 100);
    period_highs(n, lo);
    chk("R9 next period width", n, 200);

    // R1: reset mid-operation
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R1 pwm in second reset", pwm_out, 0);
    chk("R1 duty in second reset", duty_out, 4);
    rst = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule